// File: doc/BRIEF.md
# Synchronous Serial Port with Master/Slave Roles

This block is a byte-oriented synchronous serial port that a CPU controls through three register addresses. It can generate the serial clock itself (master) or follow an external clock and select line (slave). Pin output enables let the same pins be turned around when several masters share one bus. When another master pulls the select line low while this block is master, it gives up the bus at once.

The transmit side has a single buffer. A write to the data address goes straight into the shift register, and a write made while a transfer is running is refused. The receive side has two buffers. The shift register hands each finished byte to a parallel read buffer, so the next byte can start while software is still reading the last one.

Four flags report events: transfer complete, write collision, mode fault and overrun. Software clears a flag in two steps. It first reads the status register while the flag is set, then accesses the data address. Overrun keeps the older byte.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the control register and the status register read 0, the clock, data-out and slave-data output enables are low, and the interrupt request is low.
- R2: In master mode each serial clock phase lasts 2^rate system clocks, where rate is control bits [7:6]. The resulting divide ratios are 2, 4, 8 and 16. One byte takes 16 clock edges, and the clock idles at the polarity level before and after the byte.
- R3: Control bit [2] sets the idle clock level. Control bit [3] selects the sampling edge: 0 samples on the leading edge with the first bit valid before it, and 1 changes data on the leading edge and samples on the trailing edge.
- R4: Control bit [4] selects LSB-first when 1 and MSB-first when 0. The setting applies to both directions.
- R5: At the end of a byte, status bit [0] (complete) sets and the received byte is readable at address 2. Address 0 is control and address 1 is status.
- R6: A write to address 2 while a transfer is running sets status bit [1] (write collision). The running transfer still shifts out the original byte.
- R7: If a byte completes while status bit [0] is still set, status bit [3] (overrun) sets and the read buffer keeps the older byte.
- R8: A status read followed by a read or write of address 2 clears every flag that was set when the status was read.
- R9: With control bits [0] (enable) and [1] (master) set, a low select input sets status bit [2] (mode fault). It also clears the master bit, stops the transfer and drops the clock and data-out enables.
- R10: In slave mode the block shifts on the externally supplied clock, provided each clock phase lasts at least SYNC_N+2 system clocks. It drives the slave-data output enable only while its select input is low.
- R11: The interrupt request follows status bit [0] when control bit [5] is set.
- R12: The control register reads back the value written to it, apart from the master bit when a mode fault clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Transfer-complete interrupt request |
| sclk_i | input | 1 | Serial clock input (slave) |
| sclk_o | output | 1 | Serial clock output (master) |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-to-slave data input (slave) |
| mosi_o | output | 1 | Master-to-slave data output |
| mosi_oe | output | 1 | Master-to-slave data output enable |
| miso_i | input | 1 | Slave-to-master data input (master) |
| miso_o | output | 1 | Slave-to-master data output |
| miso_oe | output | 1 | Slave-to-master data output enable |
| ss_n_i | input | 1 | Active-low select input; a mode fault when the block is master |

## Verification
The bench uses the defaults DATA_W=8 and SYNC_N=2, so all four rate settings are reachable, from the divide-by-2 setting up to divide-by-16. A bench-side slave returns a known byte, so both bit orders and all four polarity/phase combinations can be checked in both directions. The bench also plays master, with clock phases of eight system clocks, to drive the slave path through its two-stage synchronisers.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int RATE_W = 2;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              irq_en;
    logic              lsb_first;
    logic              cpha;
    logic              cpol;
    logic              master;
    logic              en;
  } ctrl_t;

  typedef struct packed {
    logic ovr;
    logic modf;
    logic wcol;
    logic done;
  } flags_t;
endpackage

// File: rtl/ssp_rate_div.sv
module ssp_rate_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = 2 ** SEL_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   half_m1;

  always_comb begin
    half_m1 = ((CNT_W+1)'(1) << sel) - (CNT_W+1)'(1);
    tick    = run && ({1'b0, cnt} == half_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R2: no back-to-back ticks unless the fastest rate is chosen
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    tick && sel != '0 |=> !tick || sel != $past(sel));
endmodule

// File: rtl/ssp_in_sync.sv
module ssp_in_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic mosi_i,
  input  logic ss_n_i,
  output logic sclk_s,
  output logic sclk_edge,
  output logic mosi_s,
  output logic ss_act
);
  logic [SYNC_N-1:0] sck_p, mo_p, ss_p;
  logic              sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p  <= '0;
      mo_p   <= '0;
      ss_p   <= '1;
      sclk_d <= 1'b0;
    end else begin
      sck_p  <= {sck_p[SYNC_N-2:0], sclk_i};
      mo_p   <= {mo_p[SYNC_N-2:0], mosi_i};
      ss_p   <= {ss_p[SYNC_N-2:0], ss_n_i};
      sclk_d <= sck_p[SYNC_N-1];
    end
  end

  assign sclk_s    = sck_p[SYNC_N-1];
  assign sclk_edge = sck_p[SYNC_N-1] ^ sclk_d;
  assign mosi_s    = mo_p[SYNC_N-1];
  assign ss_act    = !ss_p[SYNC_N-1];
endmodule

// File: rtl/ssp_shift_engine.sv
module ssp_shift_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              ev,
  input  logic              lead,
  input  logic              sin,
  output logic              txd,
  output logic              busy,
  output logic              at_last,
  output logic              xfer_done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int EC_W = $clog2(2 * DATA_W);
  localparam logic [EC_W-1:0] LAST = EC_W'(2 * DATA_W - 1);

  logic [DATA_W-1:0] tx_sh, rx_sh, rx_next;
  logic [EC_W-1:0]   ecnt;
  logic              drive, samp, head, load_head;

  function automatic logic [DATA_W-1:0] advance(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  always_comb begin
    drive     = ev && (cpha ? lead : !lead);
    samp      = ev && (cpha ? !lead : lead);
    head      = lsb_first ? tx_sh[0] : tx_sh[DATA_W-1];
    load_head = lsb_first ? load_data[0] : load_data[DATA_W-1];
    rx_next   = lsb_first ? {sin, rx_sh[DATA_W-1:1]} : {rx_sh[DATA_W-2:0], sin};
    at_last   = (ecnt == LAST);
    busy      = (ecnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh     <= '0;
      rx_sh     <= '0;
      rx_word   <= '0;
      ecnt      <= '0;
      txd       <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      if (clear) begin
        ecnt <= '0;
      end else if (ev) begin
        ecnt <= at_last ? '0 : ecnt + 1'b1;
        if (at_last) begin
          xfer_done <= 1'b1;
          rx_word   <= samp ? rx_next : rx_sh;
        end
      end
      if (samp && !clear) rx_sh <= rx_next;
      if (load) begin
        if (cpha) begin
          tx_sh <= load_data;
        end else begin
          tx_sh <= advance(load_data, lsb_first);
          txd   <= load_head;
        end
      end else if (drive && !clear) begin
        txd   <= head;
        tx_sh <= advance(tx_sh, lsb_first);
      end
    end
  end

  // R5: completion is a single-cycle event per byte
  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq_o,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_n_i
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl;
  flags_t            flg, flg_nx, armed;
  logic              running, sclk_q, irq_q, take_rx;
  logic [DATA_W-1:0] rxbuf;

  logic sclk_s, sclk_edge, mosi_s, ss_act, tick;
  logic eng_txd, eng_busy, eng_last, eng_done;
  logic [DATA_W-1:0] eng_rx;

  logic wr_ctrl, rd_stat, wr_data, data_acc, fault, busy, accept, collide;
  logic m_ev, m_lead, s_ev, s_lead, ev, lead, eng_clear, sin;

  always_comb begin
    wr_ctrl   = cpu_wr && cpu_addr == ADDR_CTRL;
    rd_stat   = cpu_rd && cpu_addr == ADDR_STAT;
    wr_data   = cpu_wr && cpu_addr == ADDR_DATA;
    data_acc  = (cpu_wr || cpu_rd) && cpu_addr == ADDR_DATA;
    fault     = ctrl.en && ctrl.master && ss_act;
    busy      = ctrl.master ? running : (ss_act && eng_busy);
    accept    = wr_data && ctrl.en && !busy && !fault;
    collide   = wr_data && ctrl.en && busy;
    m_ev      = running && tick;
    m_lead    = (sclk_q == ctrl.cpol);
    s_ev      = ctrl.en && !ctrl.master && ss_act && sclk_edge;
    s_lead    = (sclk_s != ctrl.cpol);
    ev        = ctrl.master ? m_ev : s_ev;
    lead      = ctrl.master ? m_lead : s_lead;
    eng_clear = !ctrl.en || fault || (!ctrl.master && !ss_act);
    sin       = ctrl.master ? miso_i : mosi_s;
  end

  ssp_in_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i),
    .sclk_s(sclk_s), .sclk_edge(sclk_edge), .mosi_s(mosi_s), .ss_act(ss_act)
  );

  ssp_rate_div #(.SEL_W(RATE_W)) u_div (
    .clk(clk), .rst(rst), .run(running), .sel(ctrl.rate), .tick(tick)
  );

  ssp_shift_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .clear(eng_clear), .load(accept), .load_data(cpu_wdata),
    .cpha(ctrl.cpha), .lsb_first(ctrl.lsb_first), .ev(ev), .lead(lead), .sin(sin),
    .txd(eng_txd), .busy(eng_busy), .at_last(eng_last), .xfer_done(eng_done),
    .rx_word(eng_rx)
  );

  // control register and master sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      running <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(cpu_wdata[CTRL_W-1:0]);
      if (fault)   ctrl.master <= 1'b0;

      if (fault || !ctrl.en || !ctrl.master) running <= 1'b0;
      else if (accept)                       running <= 1'b1;
      else if (m_ev && eng_last)             running <= 1'b0;

      if (!running)  sclk_q <= ctrl.cpol;
      else if (tick) sclk_q <= ~sclk_q;
    end
  end

  // status flags: set events win over the two-step clear
  always_comb begin
    flg_nx  = flg;
    take_rx = 1'b0;
    if (data_acc) flg_nx = flags_t'(flg & ~armed);
    if (collide)  flg_nx.wcol = 1'b1;
    if (fault)    flg_nx.modf = 1'b1;
    if (eng_done) begin
      if (flg_nx.done) flg_nx.ovr = 1'b1;
      else begin
        flg_nx.done = 1'b1;
        take_rx     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg       <= '0;
      armed     <= '0;
      rxbuf     <= '0;
      irq_q     <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      flg <= flg_nx;
      if (data_acc)     armed <= '0;
      else if (rd_stat) armed <= flags_t'(armed | flg);
      if (take_rx) rxbuf <= eng_rx;
      irq_q <= ctrl.irq_en && flg.done;
      if (cpu_rd) begin
        case (cpu_addr)
          ADDR_CTRL: cpu_rdata <= DATA_W'(ctrl);
          ADDR_STAT: cpu_rdata <= DATA_W'(flg);
          ADDR_DATA: cpu_rdata <= rxbuf;
          default:   cpu_rdata <= '0;
        endcase
      end
    end
  end

  assign irq_o   = irq_q;
  assign sclk_o  = sclk_q;
  assign mosi_o  = eng_txd;
  assign miso_o  = eng_txd;
  assign sclk_oe = ctrl.en && ctrl.master;
  assign mosi_oe = ctrl.en && ctrl.master;
  assign miso_oe = ctrl.en && !ctrl.master && ss_act;

  // R2: after the final master edge the clock is back at its idle level
  p_last_edge_idle_r2: assert property (@(posedge clk) disable iff (rst)
    m_ev && eng_last && $stable(ctrl.cpol) |=> sclk_q == ctrl.cpol);

  // R6: a write during a transfer raises the collision flag
  p_wcol_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_wr && cpu_addr == ADDR_DATA && ctrl.en && busy |=> flg.wcol);

  // R7: an overrun keeps the older byte
  p_ovr_keeps_old_r7: assert property (@(posedge clk) disable iff (rst)
    eng_done && flg.done && !(data_acc && armed.done) |=> $stable(rxbuf) && flg.ovr);

  // R8: an armed complete flag is cleared by the data access
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    data_acc && armed.done && !eng_done |=> !flg.done);

  // R9: a select from another master forces slave role and a fault
  p_modf_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl.en && ctrl.master && ss_act |=> !ctrl.master && flg.modf && !running);

  // R11: interrupt follows the complete flag when enabled
  p_irq_r11: assert property (@(posedge clk) disable iff (rst)
    flg.done && ctrl.irq_en |=> irq_o);
endmodule

// File: tb/sync_serial_port_test.sv
module sync_serial_port_test;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;
  // ctrl[23:16], tx byte[15:8], bench-slave reply[7:0]
  localparam logic [23:0] VEC [0:5] = '{
    24'h03_A5_3C, 24'h47_5A_C3, 24'h8B_81_7E,
    24'hCF_96_0F, 24'h13_1E_B4, 24'h5F_E1_2D
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [1:0] cpu_addr = 2'd0;
  logic [7:0] cpu_wdata = 8'd0, cpu_rdata;
  logic irq_o, sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic sclk_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1, miso_i;

  logic [7:0] m_reply = 8'd0, m_cap = 8'd0;
  logic m_cpol = 1'b0, m_cpha = 1'b0, model_on = 1'b0;
  int edges = 0, first_c = 0, last_c = 0, cyc = 0;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;
  assign miso_i = m_reply[7];

  sync_serial_port uut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq_o(irq_o),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
  );

  // bench-side slave for master tests: shifts MSB-first on its sample edges
  always @(sclk_o) begin
    if (model_on) begin
      edges = edges + 1;
      if (edges == 1) first_c = cyc;
      last_c = cyc;
      if ((sclk_o != m_cpol) ^ m_cpha) begin
        m_cap   = {m_cap[6:0], mosi_o};
        m_reply = {m_reply[6:0], 1'b0};
      end
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk); cpu_rd = 1'b0; d = cpu_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prep_model(input logic cpol, input logic cpha, input logic [7:0] reply);
    model_on = 1'b0; idle(3);
    m_cpol = cpol; m_cpha = cpha; m_reply = reply; m_cap = 8'd0; edges = 0;
    model_on = 1'b1;
  endtask

  task automatic wait_done(output logic [7:0] s);
    s = 8'd0;
    for (int k = 0; k < 400; k++) begin
      rd(A_STAT, s);
      if (s[0]) break;
    end
  endtask

  task automatic slave_xfer(input logic cpol, input logic cpha, input logic [7:0] send,
                            output logic [7:0] got, output logic oe_mid);
    got = 8'd0;
    sclk_i = cpol; idle(8);
    ss_n_i = 1'b0; idle(8);
    for (int i = 7; i >= 0; i--) begin
      if (!cpha) mosi_i = send[i];
      idle(8);
      if (!cpha) got[i] = miso_o;
      sclk_i = ~cpol;
      if (cpha) mosi_i = send[i];
      idle(8);
      if (cpha) got[i] = miso_o;
      sclk_i = cpol;
    end
    idle(8);
    oe_mid = miso_oe;
    ss_n_i = 1'b1; idle(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s, d, got;
    logic oe;
    idle(4); rst = 1'b0; idle(2);

    // R1: reset state
    rd(A_CTRL, d); chk("R1 ctrl", d, 8'h00);
    rd(A_STAT, s); chk("R1 status", s, 8'h00);
    chk("R1 enables", {sclk_oe, mosi_oe, miso_oe, irq_o}, 4'b0000);

    // table walk: master transfers over rates, modes and bit orders
    foreach (VEC[v]) begin
      logic [7:0] c, tx, rep;
      int half;
      c = VEC[v][23:16]; tx = VEC[v][15:8]; rep = VEC[v][7:0];
      half = 1 << c[7:6];
      wr(A_CTRL, c);
      rd(A_CTRL, d); chk("R12 ctrl readback", d, c);
      prep_model(c[2], c[3], rep);
      wr(A_DATA, tx);
      wait_done(s);
      idle(2);
      chk("R3/R4 mosi bits", m_cap, c[4] ? rev8(tx) : tx);
      rd(A_DATA, d); chk("R5/R4 rx byte", d, c[4] ? rev8(rep) : rep);
      chk("R2 edge count", edges, 16);
      chk("R2 edge span", last_c - first_c, 15 * half);
      chk("R2 idle level", sclk_o, c[2]);
      rd(A_STAT, s); chk("R8 flags cleared", s, 8'h00);
    end

    // R11: interrupt request
    wr(A_CTRL, 8'h23); prep_model(1'b0, 1'b0, 8'h00);
    wr(A_DATA, 8'h05); idle(60);
    chk("R11 irq set", irq_o, 1'b1);
    rd(A_STAT, s); rd(A_DATA, d); idle(3);
    chk("R11 irq cleared", irq_o, 1'b0);

    // R6: write collision leaves the running byte untouched
    wr(A_CTRL, 8'hC3); prep_model(1'b0, 1'b0, 8'h00);
    wr(A_DATA, 8'hA5); idle(20);
    wr(A_DATA, 8'hFF); idle(200);
    rd(A_STAT, s); chk("R6 wcol and done", s, 8'h03);
    chk("R6 shifted byte", m_cap, 8'hA5);
    rd(A_DATA, d);
    rd(A_STAT, s); chk("R8 both cleared", s, 8'h00);

    // R7: overrun keeps the first byte
    wr(A_CTRL, 8'h03); prep_model(1'b0, 1'b0, 8'h22);
    wr(A_DATA, 8'h11); idle(60);
    m_reply = 8'h44;
    wr(A_DATA, 8'h33); idle(60);
    rd(A_STAT, s); chk("R7 overrun flag", s, 8'h09);
    rd(A_DATA, d); chk("R7 older byte kept", d, 8'h22);
    rd(A_STAT, s); chk("R8 overrun cleared", s, 8'h00);

    // R9: mode fault from another master
    model_on = 1'b0;
    wr(A_CTRL, 8'h03);
    ss_n_i = 1'b0; idle(6);
    rd(A_CTRL, d); chk("R9 master bit dropped", d, 8'h01);
    chk("R9 drivers off", {sclk_oe, mosi_oe}, 2'b00);
    ss_n_i = 1'b1; idle(6);
    rd(A_STAT, s); chk("R9 modf flag", s, 8'h04);
    rd(A_DATA, d);
    rd(A_STAT, s); chk("R8 modf cleared", s, 8'h00);

    // R10: slave mode, leading-edge sampling, idle-low clock
    wr(A_CTRL, 8'h01); wr(A_DATA, 8'h6B);
    slave_xfer(1'b0, 1'b0, 8'hD2, got, oe);
    chk("R10 miso enable while selected", oe, 1'b1);
    chk("R10 miso enable released", miso_oe, 1'b0);
    chk("R10 slave tx", got, 8'h6B);
    wait_done(s); chk("R10 slave done", s, 8'h01);
    rd(A_DATA, d); chk("R10 slave rx", d, 8'hD2);

    // R10: slave mode, trailing-edge sampling, idle-high clock
    wr(A_CTRL, 8'h0D); wr(A_DATA, 8'h3C);
    slave_xfer(1'b1, 1'b1, 8'h99, got, oe);
    chk("R10 slave tx mode 3", got, 8'h3C);
    wait_done(s);
    rd(A_DATA, d); chk("R10 slave rx mode 3", d, 8'h99);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule